// File: doc/BRIEF.md
# Per-Block Clock-Enable and Set/Reset Generator

This block produces the shared control lines of one logic block inside a larger programmable fabric. Everything runs in a single system-clock domain. Each "clock" is a one-cycle enable strobe rather than a real clock. Four clock-enable lines and three set/reset lines leave the block, and every storage element of the logic block can pick any of them.

Each clock line takes its source from a static configuration word. The source can be a sampled global clock with rising-edge, falling-edge or both-edge detection. Line 0 and line 2 can instead use the rising edge of a three-input AND term. Line 0 can also use the rising edge of a three-input OR term. The odd lines can act as the complement of their even neighbour: they strobe on the opposite edge of the same global source. Only three of the four global clocks reach a block, and a parameter names the missing one.

Each set/reset line picks one of two sources: a global reset input or a three-input AND term. It has a programmable polarity and is registered so that it cannot glitch. A selection that a line does not support, including a global clock that is not available, holds that line inactive.

The design has no state machine. Its only state is one sample register per source and one output register per line, so no states or transitions are listed.

Top module: `blkctl_gen`

## Requirements
- R1: After reset, and until the first source edge, `ck_out` and `sr_out` are all 0.
- R2: Clock line n is configured by mode field `cfg_ck_mode[3n+2:3n]` and global select `cfg_ck_gsel[2n+1:2n]`. With mode 1 (global rising), the line is high for exactly one cycle after the first clock edge at which the selected `gclk_in` bit is sampled 1 after being sampled 0. It does not strobe on the falling edge.
- R3: Mode 2 (global falling) behaves like R2 on a 1-to-0 transition and does not strobe on a 0-to-1 transition.
- R4: Mode 3 (global both-edge, lines 2 and 3 only) gives one strobe for each transition of the selected global clock.
- R5: Mode 4 (product term) strobes once after the AND of all bits goes from 0 to 1. Line 0 uses `pt0_terms` and line 2 uses `pt1_terms`. A falling product term gives no strobe.
- R6: Mode 5 (sum term, line 0 only) strobes once after the OR of `st_terms` goes from 0 to 1. It gives no strobe while the OR stays 1 or when it falls.
- R7: Mode 6 (complement, lines 1 and 3 only) strobes on the opposite edge of the global source of line n-1. This works only when line n-1 is in mode 1 or mode 2. The two lines of a complementary pair never strobe in the same cycle, and a complement line whose partner is in any other mode stays 0.
- R8: A line stays 0 in each of these cases: mode 0; mode 7; a mode outside the line's set; or a global mode (1, 2 or 3) whose select equals `UNAVAIL_GCLK` (3 by default). The line sets are: line 0 {1,2,4,5}, line 1 {1,2,6}, line 2 {1,2,3,4}, line 3 {1,2,3,6}.
- R9: Set/reset line i is configured by `cfg_sr_sel[2i+1:2i]` and `cfg_sr_pol[i]`. With select 1, `sr_out[i]` equals `grst_in` XOR polarity, one clock after sampling.
- R10: With select 2, `sr_out[i]` equals the AND of `sr_terms[3i+2:3i]` XOR polarity, one clock after sampling.
- R11: Select 0 or select 3 holds `sr_out[i]` at 0 for either polarity.
- R12: Lines are independent. Edges on different sources in the same cycle strobe every line that selects them, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ck_mode | input | 12 | Mode field, 3 bits per clock line |
| cfg_ck_gsel | input | 8 | Global clock select, 2 bits per clock line |
| cfg_sr_sel | input | 6 | Source select, 2 bits per set/reset line |
| cfg_sr_pol | input | 3 | Polarity, 1 bit per set/reset line (1 inverts) |
| gclk_in | input | 4 | Sampled global clock levels |
| pt0_terms | input | 3 | Inputs of product-term clock 0 |
| pt1_terms | input | 3 | Inputs of product-term clock 1 |
| st_terms | input | 3 | Inputs of the sum-term clock |
| grst_in | input | 1 | Global set/reset level |
| sr_terms | input | 9 | Product-term inputs, 3 per set/reset line |
| ck_out | output | 4 | Clock-enable strobes |
| sr_out | output | 3 | Registered set/reset lines |

## Verification
Two functions can fall in the same cycle. In the first case, a global clock edge, a product-term edge and a change of the global reset are all made to arrive at the same clock edge. The bench then requires the clock lines on those sources and the affected set/reset line to change together in the following cycle. In the second case, a complementary pair shares one source. That source is toggled, and the bench requires each transition to strobe exactly one line of the pair, never both; an assertion repeats this check on every cycle in which the pair configuration is stable.

// File: rtl/blkctl_pkg.sv
package blkctl_pkg;

    localparam int N_CK   = 4;
    localparam int MODE_W = 3;
    localparam int SRSEL_W = 2;

    typedef enum logic [MODE_W-1:0] {
        CK_OFF   = 3'd0,
        CK_GRISE = 3'd1,
        CK_GFALL = 3'd2,
        CK_GBOTH = 3'd3,
        CK_PTERM = 3'd4,
        CK_STERM = 3'd5,
        CK_COMP  = 3'd6,
        CK_RSVD  = 3'd7
    } ck_mode_e;

    typedef enum logic [SRSEL_W-1:0] {
        SR_OFF   = 2'd0,
        SR_GRST  = 2'd1,
        SR_PTERM = 2'd2,
        SR_RSVD  = 2'd3
    } sr_src_e;

    function automatic logic is_global(input ck_mode_e m);
        return (m == CK_GRISE) || (m == CK_GFALL) || (m == CK_GBOTH);
    endfunction

    // Option set of each clock line
    function automatic logic mode_allowed(input int line, input ck_mode_e m);
        logic ok;
        ok = (m == CK_GRISE) || (m == CK_GFALL);
        if (line == 0) ok = ok || (m == CK_PTERM) || (m == CK_STERM);
        if (line == 1) ok = ok || (m == CK_COMP);
        if (line == 2) ok = ok || (m == CK_GBOTH) || (m == CK_PTERM);
        if (line == 3) ok = ok || (m == CK_GBOTH) || (m == CK_COMP);
        return ok;
    endfunction

endpackage

// File: rtl/blkctl_edge.sv
module blkctl_edge #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_in,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig_in;
    end

    always_comb begin
        rise = sig_in & ~sig_q;
        fall = ~sig_in & sig_q;
    end

endmodule

// File: rtl/blkctl_ck_line.sv
module blkctl_ck_line
    import blkctl_pkg::*;
#(
    parameter int LINE         = 0,
    parameter int N_GCLK       = 4,
    parameter int UNAVAIL_GCLK = 3,
    localparam int GSEL_W      = $clog2(N_GCLK)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MODE_W-1:0]    mode_raw,
    input  logic [GSEL_W-1:0]    gsel,
    input  logic [MODE_W-1:0]    partner_mode_raw,
    input  logic [GSEL_W-1:0]    partner_gsel,
    input  logic [N_GCLK-1:0]    g_rise,
    input  logic [N_GCLK-1:0]    g_fall,
    input  logic                 pt_rise,
    input  logic                 st_rise,
    output logic                 strobe_q
);

    localparam logic [GSEL_W-1:0] MISSING = GSEL_W'(UNAVAIL_GCLK);

    ck_mode_e mode;
    ck_mode_e pmode;
    logic     legal;
    logic     hit;

    always_comb begin
        mode  = ck_mode_e'(mode_raw);
        pmode = ck_mode_e'(partner_mode_raw);
        legal = mode_allowed(LINE, mode) && !(is_global(mode) && gsel == MISSING);
        hit   = 1'b0;
        unique case (mode)
            CK_GRISE: hit = g_rise[gsel];
            CK_GFALL: hit = g_fall[gsel];
            CK_GBOTH: hit = g_rise[gsel] | g_fall[gsel];
            CK_PTERM: hit = pt_rise;
            CK_STERM: hit = st_rise;
            CK_COMP: begin
                if (partner_gsel == MISSING)  hit = 1'b0;
                else if (pmode == CK_GRISE)   hit = g_fall[partner_gsel];
                else if (pmode == CK_GFALL)   hit = g_rise[partner_gsel];
                else                          hit = 1'b0;
            end
            default:  hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= legal & hit;
    end

    // An unsupported selection never produces a strobe
    assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |=> !strobe_q);

    // A single-edge source cannot strobe on two cycles in a row while the config is held
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_q && $stable(mode_raw) && $stable(gsel) && mode != CK_GBOTH && mode != CK_COMP)
        |=> !strobe_q || !$stable(mode_raw) || !$stable(gsel));

endmodule

// File: rtl/blkctl_sr_line.sv
module blkctl_sr_line
    import blkctl_pkg::*;
#(
    parameter int TERM_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRSEL_W-1:0] sel_raw,
    input  logic               pol,
    input  logic               grst_in,
    input  logic [TERM_W-1:0]  terms,
    output logic               sr_q
);

    sr_src_e src;
    logic    nxt;

    always_comb begin
        src = sr_src_e'(sel_raw);
        nxt = 1'b0;
        unique case (src)
            SR_GRST:  nxt = grst_in ^ pol;
            SR_PTERM: nxt = (&terms) ^ pol;
            default:  nxt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= 1'b0;
        else        sr_q <= nxt;
    end

    // Global reset source follows its input one cycle later
    assert_grst_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_raw == 2'd1) |=> (sr_q == ($past(grst_in) ^ $past(pol))));

    // Off and reserved selections stay inactive
    assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_raw == 2'd0 || sel_raw == 2'd3) |=> !sr_q);

endmodule

// File: rtl/blkctl_gen.sv
module blkctl_gen
    import blkctl_pkg::*;
#(
    parameter int N_GCLK       = 4,
    parameter int UNAVAIL_GCLK = 3,
    parameter int TERM_W       = 3,
    parameter int N_SR         = 3,
    localparam int GSEL_W      = $clog2(N_GCLK)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CK*MODE_W-1:0]     cfg_ck_mode,
    input  logic [N_CK*GSEL_W-1:0]     cfg_ck_gsel,
    input  logic [N_SR*SRSEL_W-1:0]    cfg_sr_sel,
    input  logic [N_SR-1:0]            cfg_sr_pol,
    input  logic [N_GCLK-1:0]          gclk_in,
    input  logic [TERM_W-1:0]          pt0_terms,
    input  logic [TERM_W-1:0]          pt1_terms,
    input  logic [TERM_W-1:0]          st_terms,
    input  logic                       grst_in,
    input  logic [N_SR*TERM_W-1:0]     sr_terms,
    output logic [N_CK-1:0]            ck_out,
    output logic [N_SR-1:0]            sr_out
);

    logic [N_GCLK-1:0] g_rise, g_fall;
    logic [2:0]        term_lvl, term_rise, term_fall;

    // Term bits: 0 = product term 0, 1 = product term 1, 2 = sum term
    assign term_lvl = {|st_terms, &pt1_terms, &pt0_terms};

    blkctl_edge #(.W(N_GCLK)) u_gedge (
        .clk(clk), .rst_n(rst_n), .sig_in(gclk_in), .rise(g_rise), .fall(g_fall)
    );

    blkctl_edge #(.W(3)) u_tedge (
        .clk(clk), .rst_n(rst_n), .sig_in(term_lvl), .rise(term_rise), .fall(term_fall)
    );

    for (genvar n = 0; n < N_CK; n++) begin : g_ck
        localparam int HAS_PARTNER = n % 2;
        logic [MODE_W-1:0] p_mode;
        logic [GSEL_W-1:0] p_gsel;
        logic              pt_r, st_r;

        if (HAS_PARTNER == 1) begin : g_odd
            assign p_mode = cfg_ck_mode[(n-1)*MODE_W +: MODE_W];
            assign p_gsel = cfg_ck_gsel[(n-1)*GSEL_W +: GSEL_W];
        end else begin : g_even
            assign p_mode = '0;
            assign p_gsel = '0;
        end

        assign pt_r = (n == 0) ? term_rise[0] : (n == 2) ? term_rise[1] : 1'b0;
        assign st_r = (n == 0) ? term_rise[2] : 1'b0;

        blkctl_ck_line #(
            .LINE(n), .N_GCLK(N_GCLK), .UNAVAIL_GCLK(UNAVAIL_GCLK)
        ) u_line (
            .clk(clk), .rst_n(rst_n),
            .mode_raw(cfg_ck_mode[n*MODE_W +: MODE_W]),
            .gsel(cfg_ck_gsel[n*GSEL_W +: GSEL_W]),
            .partner_mode_raw(p_mode),
            .partner_gsel(p_gsel),
            .g_rise(g_rise), .g_fall(g_fall),
            .pt_rise(pt_r), .st_rise(st_r),
            .strobe_q(ck_out[n])
        );
    end

    for (genvar i = 0; i < N_SR; i++) begin : g_sr
        blkctl_sr_line #(.TERM_W(TERM_W)) u_sr (
            .clk(clk), .rst_n(rst_n),
            .sel_raw(cfg_sr_sel[i*SRSEL_W +: SRSEL_W]),
            .pol(cfg_sr_pol[i]),
            .grst_in(grst_in),
            .terms(sr_terms[i*TERM_W +: TERM_W]),
            .sr_q(sr_out[i])
        );
    end

    // Line 0 rising on global 0 strobes after a sampled rise
    assert_grise_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ck_mode[2:0] == 3'd1 && cfg_ck_gsel[1:0] == '0 && $rose(gclk_in[0])) |=> ck_out[0]);

    // A complementary pair never strobes together
    assert_comp_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ck_mode[5:3] == 3'd6 && $stable(cfg_ck_mode) && $stable(cfg_ck_gsel))
        |-> !(ck_out[0] && ck_out[1]));

    // Falling product terms and sum terms give no strobe
    assert_pt0_fall_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ck_mode[2:0] == 3'd4 && term_fall[0]) |=> !ck_out[0]);
    assert_pt1_fall_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ck_mode[8:6] == 3'd4 && term_fall[1]) |=> !ck_out[2]);
    assert_st_fall_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ck_mode[2:0] == 3'd5 && term_fall[2]) |=> !ck_out[0]);

endmodule

// File: tb/blkctl_gen_tb.sv
module blkctl_gen_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cfg_ck_mode = '0;
    logic [7:0]  cfg_ck_gsel = '0;
    logic [5:0]  cfg_sr_sel = '0;
    logic [2:0]  cfg_sr_pol = '0;
    logic [3:0]  gclk_in = '0;
    logic [2:0]  pt0_terms = '0, pt1_terms = '0, st_terms = '0;
    logic        grst_in = 1'b0;
    logic [8:0]  sr_terms = '0;
    logic [3:0]  ck_out;
    logic [2:0]  sr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blkctl_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_ck_mode(cfg_ck_mode), .cfg_ck_gsel(cfg_ck_gsel),
        .cfg_sr_sel(cfg_sr_sel), .cfg_sr_pol(cfg_sr_pol),
        .gclk_in(gclk_in), .pt0_terms(pt0_terms), .pt1_terms(pt1_terms),
        .st_terms(st_terms), .grst_in(grst_in), .sr_terms(sr_terms),
        .ck_out(ck_out), .sr_out(sr_out)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_ck(input int line, input logic [2:0] mode, input logic [1:0] gsel);
        cfg_ck_mode[3*line +: 3] = mode;
        cfg_ck_gsel[2*line +: 2] = gsel;
    endtask

    task automatic set_sr(input int line, input logic [1:0] sel, input logic pol);
        cfg_sr_sel[2*line +: 2] = sel;
        cfg_sr_pol[line] = pol;
    endtask

    task automatic clear_all();
        cfg_ck_mode = '0; cfg_ck_gsel = '0; cfg_sr_sel = '0; cfg_sr_pol = '0;
        gclk_in = '0; pt0_terms = '0; pt1_terms = '0; st_terms = '0;
        grst_in = 1'b0; sr_terms = '0;
        step(); step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        check("R1 ck reset", {28'd0, ck_out}, 32'd0);
        check("R1 sr reset", {29'd0, sr_out}, 32'd0);
        rst_n = 1'b1;
        step();
        check("R1 ck after release", {28'd0, ck_out}, 32'd0);
        check("R1 sr after release", {29'd0, sr_out}, 32'd0);
    endtask

    task automatic t_grise();
        clear_all();
        set_ck(0, 3'd1, 2'd0);
        set_ck(1, 3'd1, 2'd2);
        gclk_in[0] = 1'b1; step();
        check("R2 rise line0", {28'd0, ck_out}, 32'h1);
        step();
        check("R2 one cycle", {28'd0, ck_out}, 32'h0);
        gclk_in[0] = 1'b0; step();
        check("R2 no strobe on fall", {28'd0, ck_out}, 32'h0);
        gclk_in[2] = 1'b1; step();
        check("R2 rise line1 gclk2", {28'd0, ck_out}, 32'h2);
    endtask

    task automatic t_gfall();
        clear_all();
        set_ck(1, 3'd2, 2'd1);
        gclk_in[1] = 1'b1; step();
        check("R3 no strobe on rise", {28'd0, ck_out}, 32'h0);
        gclk_in[1] = 1'b0; step();
        check("R3 fall strobe", {28'd0, ck_out}, 32'h2);
        step();
        check("R3 one cycle", {28'd0, ck_out}, 32'h0);
    endtask

    task automatic t_gboth();
        clear_all();
        set_ck(2, 3'd3, 2'd0);
        set_ck(3, 3'd3, 2'd2);
        gclk_in[0] = 1'b1; step();
        check("R4 both rise", {28'd0, ck_out}, 32'h4);
        step();
        check("R4 idle", {28'd0, ck_out}, 32'h0);
        gclk_in[0] = 1'b0; gclk_in[2] = 1'b1; step();
        check("R4 both fall and rise", {28'd0, ck_out}, 32'hC);
    endtask

    task automatic t_pterm();
        clear_all();
        set_ck(0, 3'd4, 2'd0);
        set_ck(2, 3'd4, 2'd0);
        pt0_terms = 3'b011; step();
        check("R5 partial AND", {28'd0, ck_out}, 32'h0);
        pt0_terms = 3'b111; step();
        check("R5 AND rise line0", {28'd0, ck_out}, 32'h1);
        step();
        check("R5 one cycle", {28'd0, ck_out}, 32'h0);
        pt1_terms = 3'b111; step();
        check("R5 AND rise line2", {28'd0, ck_out}, 32'h4);
        pt0_terms = 3'b101; pt1_terms = 3'b000; step();
        check("R5 fall quiet", {28'd0, ck_out}, 32'h0);
    endtask

    task automatic t_sterm();
        clear_all();
        set_ck(0, 3'd5, 2'd0);
        st_terms = 3'b001; step();
        check("R6 OR rise", {28'd0, ck_out}, 32'h1);
        st_terms = 3'b011; step();
        check("R6 OR stays high", {28'd0, ck_out}, 32'h0);
        st_terms = 3'b000; step();
        check("R6 OR fall quiet", {28'd0, ck_out}, 32'h0);
        st_terms = 3'b100; step();
        check("R6 OR rise again", {28'd0, ck_out}, 32'h1);
    endtask

    task automatic t_comp();
        clear_all();
        set_ck(0, 3'd1, 2'd1);
        set_ck(1, 3'd6, 2'd0);
        gclk_in[1] = 1'b1; step();
        check("R7 pair rise", {28'd0, ck_out}, 32'h1);
        gclk_in[1] = 1'b0; step();
        check("R7 pair fall", {28'd0, ck_out}, 32'h2);
        set_ck(0, 3'd2, 2'd1);
        step();
        gclk_in[1] = 1'b1; step();
        check("R7 swapped rise", {28'd0, ck_out}, 32'h2);
        gclk_in[1] = 1'b0; step();
        check("R7 swapped fall", {28'd0, ck_out}, 32'h1);
        clear_all();
        set_ck(2, 3'd3, 2'd0);
        set_ck(3, 3'd6, 2'd0);
        gclk_in[0] = 1'b1; step();
        check("R7 partner both-edge", {28'd0, ck_out}, 32'h4);
        set_ck(0, 3'd4, 2'd0);
        set_ck(1, 3'd6, 2'd0);
        pt0_terms = 3'b111; step();
        check("R7 partner product term", {28'd0, ck_out}, 32'h1);
    endtask

    task automatic t_illegal();
        clear_all();
        set_ck(0, 3'd1, 2'd3);
        set_ck(1, 3'd4, 2'd0);
        set_ck(2, 3'd7, 2'd0);
        set_ck(3, 3'd5, 2'd0);
        gclk_in = 4'hF; pt0_terms = 3'b111; pt1_terms = 3'b111; st_terms = 3'b111;
        step();
        check("R8 illegal rise", {28'd0, ck_out}, 32'h0);
        set_ck(1, 3'd3, 2'd0);
        set_ck(2, 3'd6, 2'd0);
        set_ck(3, 3'd2, 2'd3);
        gclk_in = 4'h0; step();
        check("R8 illegal fall", {28'd0, ck_out}, 32'h0);
        set_ck(0, 3'd0, 2'd0);
        gclk_in = 4'hF; step();
        check("R8 off", {28'd0, ck_out}, 32'h0);
    endtask

    task automatic t_sr_global();
        clear_all();
        set_sr(0, 2'd1, 1'b0);
        set_sr(1, 2'd1, 1'b1);
        step();
        check("R9 grst low", {29'd0, sr_out}, 32'h2);
        grst_in = 1'b1; step();
        check("R9 grst high", {29'd0, sr_out}, 32'h1);
    endtask

    task automatic t_sr_pterm();
        clear_all();
        set_sr(2, 2'd2, 1'b0);
        sr_terms[8:6] = 3'b110; step();
        check("R10 partial", {29'd0, sr_out}, 32'h0);
        sr_terms[8:6] = 3'b111; step();
        check("R10 AND true", {29'd0, sr_out}, 32'h4);
        cfg_sr_pol[2] = 1'b1; step();
        check("R10 inverted", {29'd0, sr_out}, 32'h0);
    endtask

    task automatic t_sr_off();
        clear_all();
        set_sr(0, 2'd0, 1'b1);
        set_sr(1, 2'd3, 1'b1);
        set_sr(2, 2'd3, 1'b0);
        sr_terms = '1; step();
        check("R11 off low grst", {29'd0, sr_out}, 32'h0);
        grst_in = 1'b1; step();
        check("R11 off high grst", {29'd0, sr_out}, 32'h0);
    endtask

    task automatic t_simul();
        clear_all();
        set_ck(0, 3'd1, 2'd0);
        set_ck(2, 3'd4, 2'd0);
        set_sr(0, 2'd1, 1'b0);
        gclk_in[0] = 1'b1; pt1_terms = 3'b111; grst_in = 1'b1;
        step();
        check("R12 ck together", {28'd0, ck_out}, 32'h5);
        check("R12 sr together", {29'd0, sr_out}, 32'h1);
    endtask

    initial begin
        t_reset();
        t_grise();
        t_gfall();
        t_gboth();
        t_pterm();
        t_sterm();
        t_comp();
        t_illegal();
        t_sr_global();
        t_sr_pterm();
        t_sr_off();
        t_simul();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule